// File: doc/BRIEF.md
# Double-Buffered Serial Converter Input Register

This block is the digital input stage of a 12-bit serial-input converter. A shift register collects the code one bit at a time from a serial data pin. Four strobe pins can clock it: three shift on a rising edge and one on a falling edge. A second register holds the code that the converter sees. That holding register copies the whole shift register when both active-low load enables are low. A separate active-low clear zeroes the holding register and leaves the shift register alone.

The whole block runs from one system clock. The strobe pins, the load pins and the serial data pin pass together through a two-stage synchronizer. Edges are found on the synchronized values, so each external edge causes exactly one shift or one load. The clear pin acts on the holding register directly and asynchronously. The holding register drives the converter code output.

Top module: `serial_dac_frontend`

## Requirements
- R1: After the system reset both registers are zero, and `dac_code` reads 0x000.
- R2: Data enters the shift register most significant bit first. After 12 shifts and a load, the first bit received appears on `dac_code[11]` and the last one on `dac_code[0]`.
- R3: Strobe pins 0, 1 and 3 shift on a rising edge and are idle low. Strobe pin 2 shifts on a falling edge and is idle high.
- R4: A strobe edge shifts only when every other strobe pin is at its idle level. Otherwise the shift register keeps its contents.
- R5: The holding register loads when the two `load_n_in` bits together become 00. While either bit is 1, it keeps its value.
- R6: A low on `clear_n` zeroes `dac_code` at once, without waiting for a clock. It wins over a load at the same time, and the output stays zero for as long as `clear_n` is low.
- R7: `clear_n` leaves the shift register unchanged. A load after the clear is released shows the contents held before the clear.
- R8: A strobe held at its active level for many cycles shifts once. A load condition held for many cycles loads once.
- R9: A load that happens in the same cycle as a shift copies the shift register value from before that shift.
- R10: A shift or load takes effect on the third rising clock edge after the pin change, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset. It takes effect asynchronously and is released on the clock. |
| ser_din | input | 1 | Serial data bit |
| strobe_in | input | 4 | Strobe pins. Bit 2 is active on a falling edge; the others are active on a rising edge. |
| load_n_in | input | 2 | Active-low load enables. A load needs both bits low. |
| clear_n | input | 1 | Asynchronous active-low clear of the holding register |
| dac_code | output | 12 | Holding register contents, sent to the converter |

## Verification
A pin change is captured by the first synchronizer stage at the next rising edge. It reaches the second stage one edge later, and the shift or load happens on the third edge, so results are due three edges after the change. The bench drives the pins just after a falling edge and steps a reference model on every rising edge using the pins sampled there. It compares `dac_code` with the model on every falling edge, when the design's registers have settled. For the clear, it checks `dac_code` a fraction of a cycle after driving `clear_n`, before any clock edge. The scenario checks read `dac_code` only after a full strobe or load pulse has completed. The latency check samples the output at the second and at the third edge after a load pin change.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_pol_e;

  // Level at which a strobe of the given polarity rests between pulses
  function automatic logic idle_level(edge_pol_e pol);
    return (pol == EDGE_FALL) ? 1'b1 : 1'b0;
  endfunction

endpackage

// File: rtl/dac_rst_sync.sv
module dac_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic sync_rst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign sync_rst_n = chain_q[STAGES-1];

endmodule

// File: rtl/dac_pin_sync.sv
module dac_pin_sync #(
  parameter int unsigned          W      = 7,
  parameter int unsigned          STAGES = 2,
  parameter logic        [W-1:0]  RST_V  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_s
);

  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = pin_i;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_V;
    end else begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= stg_d[s];
    end
  end

  assign pin_s = stg_q[STAGES-1];

endmodule

// File: rtl/dac_event_gen.sv
module dac_event_gen
  import dac_fe_pkg::*;
#(
  parameter int unsigned          NS        = 4,
  parameter int unsigned          NL        = 2,
  parameter logic        [NS-1:0] FALL_MASK = 4'b0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] stb_s,
  input  logic [NL-1:0] ld_s,
  output logic          shift_pulse,
  output logic          load_pulse
);

  logic [NS-1:0] act_now, act_prev_q, act_prev_d, idle_now, stb_ok;
  logic          ld_low_now, ld_low_prev_q, ld_low_prev_d;

  // A strobe is active when it differs from its idle level
  always_comb begin
    for (int i = 0; i < NS; i++) begin
      act_now[i] = stb_s[i] ^ idle_level(edge_pol_e'(FALL_MASK[i]));
    end
  end
  assign idle_now = ~act_now;

  generate
    for (genvar gi = 0; gi < NS; gi++) begin : g_qual
      localparam logic [NS-1:0] SELF = NS'(1) << gi;
      assign stb_ok[gi] = act_now[gi] & ~act_prev_q[gi] & (&(idle_now | SELF));
    end
  endgenerate

  assign ld_low_now = ~|ld_s;

  always_comb begin
    act_prev_d    = act_now;
    ld_low_prev_d = ld_low_now;
    shift_pulse   = |stb_ok;
    load_pulse    = ld_low_now & ~ld_low_prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_prev_q    <= '0;
      ld_low_prev_q <= 1'b0;
    end else begin
      act_prev_q    <= act_prev_d;
      ld_low_prev_q <= ld_low_prev_d;
    end
  end

  AST_SHIFT_ONCE_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_pulse |=> !shift_pulse); // R8
  AST_LOAD_ONCE_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> !load_pulse); // R8

endmodule

// File: rtl/dac_shift_reg.sv
module dac_shift_reg #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (shift_en) q_d = {q[W-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

  AST_SHIFT_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (q[W-1:1] == $past(q[W-2:0])) && (q[0] == $past(bit_in))); // R2
  AST_SHIFT_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(q)); // R4

endmodule

// File: rtl/dac_hold_reg.sv
module dac_hold_reg #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_n,
  input  logic         load_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;
  logic         arst_n;

  assign arst_n = rst_n & clear_n;

  always_comb begin
    q_d = q;
    if (load_en) q_d = d;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= '0;
    else         q <= q_d;
  end

  AST_CLEAR_FORCES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |-> (q == '0)); // R6
  AST_LOAD_TAKES_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && clear_n) |=> (!clear_n || q == $past(d))); // R5
  AST_NO_LOAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && clear_n) |=> (!clear_n || $stable(q))); // R5

endmodule

// File: rtl/serial_dac_frontend.sv
module serial_dac_frontend #(
  parameter int unsigned                DATA_W      = 12,
  parameter int unsigned                NUM_STB     = 4,
  parameter int unsigned                NUM_LD      = 2,
  parameter int unsigned                SYNC_STAGES = 2,
  parameter logic        [NUM_STB-1:0]  FALL_MASK   = 4'b0100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_din,
  input  logic [NUM_STB-1:0] strobe_in,
  input  logic [NUM_LD-1:0]  load_n_in,
  input  logic               clear_n,
  output logic [DATA_W-1:0]  dac_code
);

  localparam int unsigned PIN_W = NUM_STB + NUM_LD + 1;
  // Synchronizer rest values: strobes idle, loads inactive high, data low
  localparam logic [PIN_W-1:0] PIN_RST = {FALL_MASK, {NUM_LD{1'b1}}, 1'b0};

  logic               sys_rst_n;
  logic [PIN_W-1:0]   pins_raw, pins_s;
  logic [NUM_STB-1:0] stb_s;
  logic [NUM_LD-1:0]  ld_s;
  logic               din_s;
  logic               shift_pulse, load_pulse;
  logic [DATA_W-1:0]  shreg_q;

  dac_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_rst_n (sys_rst_n)
  );

  assign pins_raw = {strobe_in, load_n_in, ser_din};

  dac_pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_V(PIN_RST)) u_pin_sync (
    .clk   (clk),
    .rst_n (sys_rst_n),
    .pin_i (pins_raw),
    .pin_s (pins_s)
  );

  assign stb_s = pins_s[PIN_W-1 -: NUM_STB];
  assign ld_s  = pins_s[NUM_LD:1];
  assign din_s = pins_s[0];

  dac_event_gen #(.NS(NUM_STB), .NL(NUM_LD), .FALL_MASK(FALL_MASK)) u_event_gen (
    .clk         (clk),
    .rst_n       (sys_rst_n),
    .stb_s       (stb_s),
    .ld_s        (ld_s),
    .shift_pulse (shift_pulse),
    .load_pulse  (load_pulse)
  );

  dac_shift_reg #(.W(DATA_W)) u_shift_reg (
    .clk      (clk),
    .rst_n    (sys_rst_n),
    .shift_en (shift_pulse),
    .bit_in   (din_s),
    .q        (shreg_q)
  );

  dac_hold_reg #(.W(DATA_W)) u_hold_reg (
    .clk     (clk),
    .rst_n   (sys_rst_n),
    .clear_n (clear_n),
    .load_en (load_pulse),
    .d       (shreg_q),
    .q       (dac_code)
  );

  AST_RESET_ZERO: assert property (@(posedge clk)
    !sys_rst_n |-> (dac_code == '0)); // R1

endmodule

// File: tb/serial_dac_frontend_bench.sv
`timescale 1ns/1ps
module serial_dac_frontend_bench;

  localparam logic [3:0] IDLE = 4'b0100;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ser_din;
  logic [3:0]  strobe_in;
  logic [1:0]  load_n_in;
  logic        clear_n;
  logic [11:0] dac_code;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  serial_dac_frontend u_serial_dac_frontend (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_din   (ser_din),
    .strobe_in (strobe_in),
    .load_n_in (load_n_in),
    .clear_n   (clear_n),
    .dac_code  (dac_code)
  );

  // Reference model: sampled pin history, newest first
  typedef struct packed {
    logic [3:0] stb;
    logic [1:0] ld;
    logic       din;
  } samp_t;

  samp_t       hist [$];
  logic [11:0] m_a, m_b;

  function automatic samp_t idle_samp();
    samp_t s;
    s.stb = IDLE; s.ld = 2'b11; s.din = 1'b0;
    return s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_a = '0; m_b = '0;
      hist.delete();
      for (int k = 0; k < 3; k++) hist.push_back(idle_samp());
    end else begin
      samp_t cur, prv, now;
      bit do_shift, do_load;
      logic [11:0] old_a;
      cur = hist[1];
      prv = hist[2];
      do_shift = 1'b0;
      for (int i = 0; i < 4; i++) begin
        bit edge_i, others_idle;
        edge_i = (cur.stb[i] != IDLE[i]) && (prv.stb[i] == IDLE[i]);
        others_idle = 1'b1;
        for (int j = 0; j < 4; j++)
          if (j != i && cur.stb[j] != IDLE[j]) others_idle = 1'b0;
        if (edge_i && others_idle) do_shift = 1'b1;
      end
      do_load = (cur.ld == 2'b00) && (prv.ld != 2'b00);
      old_a = m_a;
      if (do_shift) m_a = {m_a[10:0], cur.din};
      if (!clear_n)     m_b = '0;
      else if (do_load) m_b = old_a;
      now.stb = strobe_in; now.ld = load_n_in; now.din = ser_din;
      hist.push_front(now);
      void'(hist.pop_back());
    end
  end

  // R10: cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      compared++;
      if (dac_code !== m_b) begin
        mismatched++;
        $display("FAIL R10 cycle compare: got %h expected %h", dac_code, m_b);
      end
    end
  end

  task automatic check(input logic [11:0] exp, input string tag);
    compared++;
    if (dac_code !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, dac_code, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic strobe_bit(input int idx, input logic b);
    ser_din = b;
    strobe_in[idx] = ~IDLE[idx];
    tick(4);
    strobe_in[idx] = IDLE[idx];
    tick(4);
  endtask

  task automatic send_word(input int idx, input logic [11:0] w);
    for (int k = 11; k >= 0; k--) strobe_bit(idx, w[k]);
  endtask

  task automatic do_load();
    load_n_in = 2'b00;
    tick(4);
    load_n_in = 2'b11;
    tick(4);
  endtask

  initial begin
    rst_n = 1'b0; ser_din = 1'b0; strobe_in = IDLE;
    load_n_in = 2'b11; clear_n = 1'b1;
    tick(5);
    rst_n = 1'b1;
    tick(6);
    check(12'h000, "R1 reset");

    send_word(0, 12'hA5C); do_load(); check(12'hA5C, "R2 msb first");
    send_word(1, 12'h3C7); do_load(); check(12'h3C7, "R3 strobe1 rise");
    send_word(2, 12'h81E); do_load(); check(12'h81E, "R3 strobe2 fall");
    send_word(3, 12'h5B1); do_load(); check(12'h5B1, "R3 strobe3 rise");

    // R4: strobe 1 held active blocks the others
    ser_din = 1'b1; strobe_in[1] = 1'b1; tick(4);
    strobe_bit(0, 1'b0);
    strobe_bit(2, 1'b0);
    strobe_in[1] = 1'b0; tick(4);
    do_load(); check(12'hB63, "R4 blocked strobes");

    // R5: single load enable low does nothing
    send_word(0, 12'h0F0);
    load_n_in = 2'b10; tick(4); load_n_in = 2'b11; tick(4);
    check(12'hB63, "R5 only bit0 low");
    load_n_in = 2'b01; tick(4); load_n_in = 2'b11; tick(4);
    check(12'hB63, "R5 only bit1 low");
    do_load(); check(12'h0F0, "R5 both low");

    // R6: asynchronous clear and its priority
    clear_n = 1'b0; #1;
    check(12'h000, "R6 async clear");
    tick(2);
    load_n_in = 2'b00; tick(4); load_n_in = 2'b11; tick(4);
    check(12'h000, "R6 load during clear");
    clear_n = 1'b1; tick(3);
    check(12'h000, "R6 after release");
    do_load(); check(12'h0F0, "R7 shift register kept");

    // R8: long strobe and long load shift or load once
    ser_din = 1'b1; strobe_in[0] = 1'b1; tick(20);
    strobe_in[0] = 1'b0; tick(4);
    load_n_in = 2'b00; tick(20); load_n_in = 2'b11; tick(4);
    check(12'h1E1, "R8 single event");

    // R9: shift and load together
    ser_din = 1'b0; strobe_in[0] = 1'b1; load_n_in = 2'b00; tick(4);
    strobe_in[0] = 1'b0; load_n_in = 2'b11; tick(4);
    check(12'h1E1, "R9 pre-shift value");
    do_load(); check(12'h3C2, "R9 post-shift value");

    // R10: latency of a load
    strobe_bit(0, 1'b1);
    load_n_in = 2'b00; tick(2);
    check(12'h3C2, "R10 not yet loaded");
    tick(1);
    check(12'h785, "R10 loaded on third edge");
    load_n_in = 2'b11; tick(4);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule